// File: doc/BRIEF.md
# DDCMP Receive Message Framer

This block sits behind a byte synchronizer on the receive side of a DDCMP link. It accepts a stream of bytes together with a flag that reports whether the synchronizer is still hunting for byte alignment. Once alignment is held, the framer watches for one of three programmable start characters. Each one opens a different message kind: data, control or maintenance. It then walks the fixed six-byte header and its two-byte CRC. For data and maintenance messages it goes on through a data field whose length comes from the header, followed by a second two-byte CRC.

Every accepted byte of a message is passed on one cycle later with a tag naming the field it belongs to. A buffer manager downstream can therefore store the message without parsing it again. On the last byte of a message the framer pulses a done strobe. In that cycle it reports the message kind, the header and data CRC results, a format error for an empty data field, and whether the header address matched one of four programmable addresses under a common bit mask. It then resumes the search for a start character.

Top module: `ddcmp_rx_framer`

## Requirements
- R1: After reset, outValid, msgDone, hdrCrcErr, dataCrcErr, fmtErr and addrMatch are all 0.
- R2: While hunting is 1, incoming bytes produce no output. If hunting becomes 1 part way through a message, that message is dropped without a msgDone, and the next start character opens a new message normally.
- R3: In the search state, a byte equal to startData, startCtrl or startMaint opens a message of kind 1 (data), 2 (control) or 3 (maintenance) respectively, and any other byte is ignored. If several start characters are equal, data takes precedence over control, and control over maintenance.
- R4: Each accepted message byte appears on outByte, with outValid high, in the cycle after it is presented. outTag carries 1 for the start character, 2 for the other header bytes, 3 for a header CRC byte, 4 for a data byte and 5 for a data CRC byte, and 0 when outValid is low.
- R5: The header is six bytes including the start character. Bytes 1 and 2 hold the data length, low byte first, and only the low 14 bits are used. Byte 5 holds the station address.
- R6: The header CRC is CRC-16 with polynomial x^16+x^15+x^2+1, processed least significant bit first (reflected constant 0xA001), with an initial value of zero. It covers the six header bytes, and the two CRC bytes follow low byte first. The header is good when the running value over all eight bytes is zero; otherwise hdrCrcErr is 1 at msgDone.
- R7: A data or maintenance message with a nonzero length carries exactly that many data bytes (tag 4), followed by two data CRC bytes (tag 5). The data CRC restarts from zero at the first data byte and uses the same rule as R6, and dataCrcErr is 1 at msgDone when the check fails. msgDone comes with the second data CRC byte.
- R8: A control message has no data field. msgDone comes with its second header CRC byte, its length field is ignored, and dataCrcErr is 0.
- R9: A data or maintenance message with a length of zero ends at its second header CRC byte, with msgDone and fmtErr both 1. fmtErr is 0 at every other msgDone.
- R10: addrMatch is 1 at msgDone when, for at least one of the four 16-bit entries in addrTable (entry i in bits 16i+15..16i), ({8'h00, address byte} & addrMask) equals (entry & addrMask). A mask bit of 0 excludes that bit position from the compare.
- R11: msgKind, hdrCrcErr, dataCrcErr, fmtErr and addrMatch are valid in the cycle where msgDone is 1, and msgDone lasts exactly one cycle.
- R12: The byte presented right after a message's final byte is already examined as a possible start character, so messages can follow back to back. Idle cycles (byteValid low) inside a message do not disturb it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hunting | input | 1 | Receiver still seeking byte alignment |
| byteValid | input | 1 | byteIn holds a received byte this cycle |
| byteIn | input | 8 | Received byte |
| startData | input | 8 | Start character for data messages |
| startCtrl | input | 8 | Start character for control messages |
| startMaint | input | 8 | Start character for maintenance messages |
| addrMask | input | 16 | Address compare mask, 1 = compare this bit |
| addrTable | input | 64 | Four 16-bit station addresses, entry 0 in the low bits |
| outValid | output | 1 | outByte/outTag hold a message byte |
| outByte | output | 8 | Message byte passed through |
| outTag | output | 3 | Field tag of outByte |
| msgDone | output | 1 | Final byte of a message, status valid |
| msgKind | output | 2 | Kind of the finished message |
| hdrCrcErr | output | 1 | Header CRC check failed |
| dataCrcErr | output | 1 | Data CRC check failed |
| fmtErr | output | 1 | Data or maintenance message with zero length |
| addrMatch | output | 1 | Header address matched a table entry |

## Verification
The bench drives messages with lengths of zero, one, a few, and more than 255 bytes. The last case catches a framer that drops the upper length byte and ends the data field hundreds of bytes early. Single-bit CRC corruptions go separately into the header and into the data, so a design that mixes up the two CRC results, or fails to restart the data CRC, reports the error on the wrong flag. A message is aborted by hunting part way through, and start characters are made to collide: a framer that keeps stale state would then misframe the next message or pick the wrong kind. A narrowed mask makes a nominally different address match, which exposes a compare that ignores the mask.

// File: rtl/ddcmp_rx_pkg.sv
package ddcmp_rx_pkg;

  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  typedef enum logic [2:0] {
    TAG_NONE  = 3'd0,
    TAG_START = 3'd1,
    TAG_HDR   = 3'd2,
    TAG_HCRC  = 3'd3,
    TAG_DATA  = 3'd4,
    TAG_DCRC  = 3'd5
  } fieldTag_e;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_CTRL  = 2'd2,
    KIND_MAINT = 2'd3
  } msgKind_e;

  // Per-byte commands from control to datapath
  typedef struct packed {
    logic      emit;
    fieldTag_e tag;
    logic      crcRestart;
    logic      crcZero;
    logic      capCntLo;
    logic      capCntHi;
    logic      capAddr;
    logic      loadRemain;
    logic      decRemain;
    logic      chkHdr;
    logic      chkData;
    logic      done;
    logic      fmt;
    msgKind_e  kind;
  } strobes_t;

  // One byte of reflected CRC-16, least significant bit first
  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [7:0] b);
    logic [15:0] r;
    r = crcIn ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/ddcmp_rx_ctrl.sv
module ddcmp_rx_ctrl
  import ddcmp_rx_pkg::*;
#(
  parameter int HDR_LEN = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hunting,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic [7:0] startData,
  input  logic [7:0] startCtrl,
  input  logic [7:0] startMaint,
  input  logic       countZero,
  input  logic       lastData,
  output strobes_t   st
);

  localparam int POS_W = $clog2(HDR_LEN + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(HDR_LEN - 1);
  localparam logic [POS_W-1:0] POS_CLO  = POS_W'(1);
  localparam logic [POS_W-1:0] POS_CHI  = POS_W'(2);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_HCRC, S_DATA, S_DCRC} state_e;

  state_e          stateQ, stateD;
  logic [POS_W-1:0] posQ, posD;
  msgKind_e        kindQ, kindD;

  always_comb begin
    st         = '0;
    st.tag     = TAG_NONE;
    st.kind    = kindQ;
    stateD     = stateQ;
    posD       = posQ;
    kindD      = kindQ;
    if (hunting) begin
      stateD = S_IDLE;
      posD   = '0;
    end else if (byteValid) begin
      unique case (stateQ)
        S_IDLE: begin
          if (byteIn == startData)       kindD = KIND_DATA;
          else if (byteIn == startCtrl)  kindD = KIND_CTRL;
          else if (byteIn == startMaint) kindD = KIND_MAINT;
          else                           kindD = KIND_NONE;
          if (kindD != KIND_NONE) begin
            st.emit       = 1'b1;
            st.tag        = TAG_START;
            st.crcRestart = 1'b1;
            posD          = POS_W'(1);
            stateD        = S_HDR;
          end
        end
        S_HDR: begin
          st.emit     = 1'b1;
          st.tag      = TAG_HDR;
          st.capCntLo = (posQ == POS_CLO);
          st.capCntHi = (posQ == POS_CHI);
          st.capAddr  = (posQ == POS_LAST);
          if (posQ == POS_LAST) begin
            posD   = '0;
            stateD = S_HCRC;
          end else begin
            posD = posQ + 1'b1;
          end
        end
        S_HCRC: begin
          st.emit = 1'b1;
          st.tag  = TAG_HCRC;
          if (posQ == '0) begin
            posD = POS_W'(1);
          end else begin
            st.chkHdr = 1'b1;
            posD      = '0;
            if (kindQ == KIND_CTRL) begin
              st.done = 1'b1;
              stateD  = S_IDLE;
            end else if (countZero) begin
              st.done = 1'b1;
              st.fmt  = 1'b1;
              stateD  = S_IDLE;
            end else begin
              st.loadRemain = 1'b1;
              st.crcZero    = 1'b1;
              stateD        = S_DATA;
            end
          end
        end
        S_DATA: begin
          st.emit      = 1'b1;
          st.tag       = TAG_DATA;
          st.decRemain = 1'b1;
          if (lastData) begin
            posD   = '0;
            stateD = S_DCRC;
          end
        end
        S_DCRC: begin
          st.emit = 1'b1;
          st.tag  = TAG_DCRC;
          if (posQ == '0) begin
            posD = POS_W'(1);
          end else begin
            st.chkData = 1'b1;
            st.done    = 1'b1;
            posD       = '0;
            stateD     = S_IDLE;
          end
        end
        default: stateD = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      posQ   <= '0;
      kindQ  <= KIND_NONE;
    end else begin
      stateQ <= stateD;
      posQ   <= posD;
      kindQ  <= kindD;
    end
  end

  // R12
  next_search_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.done |=> stateQ == S_IDLE);

endmodule

// File: rtl/ddcmp_rx_datapath.sv
module ddcmp_rx_datapath
  import ddcmp_rx_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int ADDR_W   = 16,
  parameter int NUM_ADDR = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [7:0]                 byteIn,
  input  strobes_t                   st,
  input  logic [ADDR_W-1:0]          addrMask,
  input  logic [NUM_ADDR*ADDR_W-1:0] addrTable,
  output logic                       countZero,
  output logic                       lastData,
  output logic                       outValid,
  output logic [7:0]                 outByte,
  output fieldTag_e                  outTag,
  output logic                       msgDone,
  output msgKind_e                   msgKind,
  output logic                       hdrCrcErr,
  output logic                       dataCrcErr,
  output logic                       fmtErr,
  output logic                       addrMatch
);

  localparam int HI_W = CNT_W - 8;

  logic [15:0]         crcQ, crcNext;
  logic                crcBad;
  logic [CNT_W-1:0]    cntQ, remainQ;
  logic [7:0]          addrQ;
  logic                hdrBadQ;
  logic [NUM_ADDR-1:0] matchVec;
  logic                matchAny;

  assign crcNext   = crcStep(st.crcRestart ? 16'h0000 : crcQ, byteIn);
  assign crcBad    = (crcNext != 16'h0000);
  assign countZero = (cntQ == '0);
  assign lastData  = (remainQ == CNT_W'(1));

  generate
    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
      assign matchVec[i] =
        ((ADDR_W'(addrQ) & addrMask) == (addrTable[i*ADDR_W +: ADDR_W] & addrMask));
    end
  endgenerate
  assign matchAny = |matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ    <= '0;
      cntQ    <= '0;
      remainQ <= '0;
      addrQ   <= '0;
      hdrBadQ <= 1'b0;
    end else begin
      if (st.crcZero)   crcQ <= '0;
      else if (st.emit) crcQ <= crcNext;
      if (st.capCntLo)  cntQ[7:0] <= byteIn;
      if (st.capCntHi)  cntQ[CNT_W-1:8] <= byteIn[HI_W-1:0];
      if (st.capAddr)   addrQ <= byteIn;
      if (st.loadRemain)     remainQ <= cntQ;
      else if (st.decRemain) remainQ <= remainQ - 1'b1;
      if (st.chkHdr)    hdrBadQ <= crcBad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outByte    <= '0;
      outTag     <= TAG_NONE;
      msgDone    <= 1'b0;
      msgKind    <= KIND_NONE;
      hdrCrcErr  <= 1'b0;
      dataCrcErr <= 1'b0;
      fmtErr     <= 1'b0;
      addrMatch  <= 1'b0;
    end else begin
      outValid <= st.emit;
      outTag   <= st.emit ? st.tag : TAG_NONE;
      if (st.emit) outByte <= byteIn;
      msgDone <= st.done;
      if (st.done) begin
        msgKind    <= st.kind;
        hdrCrcErr  <= st.chkHdr ? crcBad : hdrBadQ;
        dataCrcErr <= st.chkData & crcBad;
        fmtErr     <= st.fmt;
        addrMatch  <= matchAny;
      end
    end
  end

  // R7
  remain_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.decRemain |-> remainQ != '0);

  // R9
  no_empty_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.loadRemain |-> cntQ != '0);

endmodule

// File: rtl/ddcmp_rx_framer.sv
module ddcmp_rx_framer
  import ddcmp_rx_pkg::*;
#(
  parameter int HDR_LEN  = 6,
  parameter int CNT_W    = 14,
  parameter int ADDR_W   = 16,
  parameter int NUM_ADDR = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hunting,
  input  logic                       byteValid,
  input  logic [7:0]                 byteIn,
  input  logic [7:0]                 startData,
  input  logic [7:0]                 startCtrl,
  input  logic [7:0]                 startMaint,
  input  logic [ADDR_W-1:0]          addrMask,
  input  logic [NUM_ADDR*ADDR_W-1:0] addrTable,
  output logic                       outValid,
  output logic [7:0]                 outByte,
  output logic [2:0]                 outTag,
  output logic                       msgDone,
  output logic [1:0]                 msgKind,
  output logic                       hdrCrcErr,
  output logic                       dataCrcErr,
  output logic                       fmtErr,
  output logic                       addrMatch
);

  strobes_t  st;
  logic      countZero, lastData;
  fieldTag_e tagOut;
  msgKind_e  kindOut;

  ddcmp_rx_ctrl #(.HDR_LEN(HDR_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .hunting(hunting), .byteValid(byteValid),
    .byteIn(byteIn), .startData(startData), .startCtrl(startCtrl),
    .startMaint(startMaint), .countZero(countZero), .lastData(lastData),
    .st(st)
  );

  ddcmp_rx_datapath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_ADDR(NUM_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .st(st),
    .addrMask(addrMask), .addrTable(addrTable),
    .countZero(countZero), .lastData(lastData),
    .outValid(outValid), .outByte(outByte), .outTag(tagOut),
    .msgDone(msgDone), .msgKind(kindOut), .hdrCrcErr(hdrCrcErr),
    .dataCrcErr(dataCrcErr), .fmtErr(fmtErr), .addrMatch(addrMatch)
  );

  assign outTag  = tagOut;
  assign msgKind = kindOut;

  // R2
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    hunting |=> !outValid);

  // R11
  done_on_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |-> outValid && $countones(outTag) != 0);

  // R8
  ctrl_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgDone && msgKind == KIND_CTRL) |-> (outTag == TAG_HCRC && !dataCrcErr && !fmtErr));

  // R9
  fmt_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgDone && fmtErr) |-> (outTag == TAG_HCRC && msgKind != KIND_CTRL));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |=> !msgDone);

endmodule

// File: tb/ddcmp_rx_framer_bench.sv
module ddcmp_rx_framer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hunting = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic [7:0]  startData = 8'h81, startCtrl = 8'h05, startMaint = 8'h90;
  logic [15:0] addrMask = 16'h00FF;
  logic [63:0] addrTable = {16'h00FF, 16'h007F, 16'h0022, 16'h0001};
  logic        outValid, msgDone, hdrCrcErr, dataCrcErr, fmtErr, addrMatch;
  logic [7:0]  outByte;
  logic [2:0]  outTag;
  logic [1:0]  msgKind;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ddcmp_rx_framer u_ddcmp_rx_framer (
    .clk(clk), .rstN(rstN), .hunting(hunting), .byteValid(byteValid), .byteIn(byteIn),
    .startData(startData), .startCtrl(startCtrl), .startMaint(startMaint),
    .addrMask(addrMask), .addrTable(addrTable), .outValid(outValid), .outByte(outByte),
    .outTag(outTag), .msgDone(msgDone), .msgKind(msgKind), .hdrCrcErr(hdrCrcErr),
    .dataCrcErr(dataCrcErr), .fmtErr(fmtErr), .addrMatch(addrMatch)
  );

  // {kind[1:0], count[13:0], addr[7:0], hdrBad, dataBad, expMatch, pad[4:0]}
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    {2'd1, 14'd3,   8'h22, 1'b0, 1'b0, 1'b1, 5'd0},
    {2'd1, 14'd1,   8'h33, 1'b0, 1'b0, 1'b0, 5'd0},
    {2'd2, 14'd0,   8'h01, 1'b0, 1'b0, 1'b1, 5'd0},
    {2'd3, 14'd5,   8'h7F, 1'b1, 1'b0, 1'b1, 5'd0},
    {2'd1, 14'd4,   8'hFF, 1'b0, 1'b1, 1'b1, 5'd0},
    {2'd3, 14'd0,   8'h01, 1'b0, 1'b0, 1'b1, 5'd0},
    {2'd2, 14'd7,   8'h44, 1'b1, 1'b0, 1'b0, 5'd0},
    {2'd1, 14'd300, 8'h10, 1'b0, 1'b0, 1'b0, 5'd0}
  };

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 16'hA001;
      else                      r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteIn = b;
    byteValid = 1'b1;
    @(posedge clk);
    #1;
    byteValid = 1'b0;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    byteValid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  logic [7:0] mb [0:511];
  logic [2:0] mt [0:511];

  task automatic sendMsg(input logic [1:0] kind, input logic [13:0] cnt, input logic [7:0] adr,
                         input bit hb, input bit db, input bit expMatch, input bit gaps);
    int n;
    logic [15:0] c;
    bit fmt, hasData;
    n = 0;
    mb[0] = (kind == 2'd1) ? startData : (kind == 2'd2) ? startCtrl : startMaint;
    mb[1] = cnt[7:0];
    mb[2] = {2'b10, cnt[13:8]};
    mb[3] = 8'h3C;
    mb[4] = adr ^ 8'h5A;
    mb[5] = adr;
    mt[0] = 3'd1;
    for (int i = 1; i < 6; i++) mt[i] = 3'd2;
    c = 16'h0;
    for (int i = 0; i < 6; i++) c = refCrc(c, mb[i]);
    mb[6] = c[7:0] ^ {7'd0, hb};
    mb[7] = c[15:8];
    mt[6] = 3'd3;
    mt[7] = 3'd3;
    n = 8;
    fmt = (kind != 2'd2) && (cnt == 0);
    hasData = (kind != 2'd2) && !fmt;
    if (hasData) begin
      c = 16'h0;
      for (int i = 0; i < int'(cnt); i++) begin
        mb[n] = 8'(i * 7 + 3);
        mt[n] = 3'd4;
        c = refCrc(c, mb[n]);
        n++;
      end
      mb[n] = c[7:0];
      mt[n] = 3'd5;
      mb[n+1] = c[15:8] ^ {7'd0, db};
      mt[n+1] = 3'd5;
      n += 2;
    end
    for (int i = 0; i < n; i++) begin
      sendByte(mb[i]);
      chk(outValid && outByte == mb[i] && outTag == mt[i], "R4 byte/tag",
          {outValid, outTag, outByte}, {1'b1, mt[i], mb[i]});
      chk(msgDone == (i == n - 1), "R11 done timing", msgDone, (i == n - 1));
      if (gaps && (i % 3 == 1)) begin
        idleCycle();
        chk(!outValid, "R12 idle gap", outValid, 0);
      end
    end
    chk(msgKind == kind, "R3 kind", msgKind, kind);
    chk(hdrCrcErr == hb, "R6 header crc", hdrCrcErr, hb);
    chk(dataCrcErr == (hasData && db), "R7 data crc", dataCrcErr, (hasData && db));
    if (kind == 2'd2) chk(!dataCrcErr && !fmtErr, "R8 control end", {dataCrcErr, fmtErr}, 0);
    chk(fmtErr == fmt, "R9 zero length", fmtErr, fmt);
    chk(addrMatch == expMatch, "R10 address", addrMatch, expMatch);
    chk(n == (hasData ? 10 + int'(cnt) : 8), "R5 length", n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!outValid && !msgDone && !hdrCrcErr && !dataCrcErr && !fmtErr && !addrMatch,
        "R1 reset", {outValid, msgDone, hdrCrcErr, dataCrcErr, fmtErr, addrMatch}, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      sendMsg(VEC[v][31:30], VEC[v][29:16], VEC[v][15:8], VEC[v][7], VEC[v][6], VEC[v][5], v[0]);
    end

    // R3: non-start byte ignored
    sendByte(8'h42);
    chk(!outValid, "R3 noise ignored", outValid, 0);

    // R2: hunting blocks start
    hunting = 1'b1;
    sendByte(startData);
    chk(!outValid, "R2 hunting ignore", outValid, 0);
    @(negedge clk);
    hunting = 1'b0;

    // R2: abort mid-message
    sendByte(startData);
    sendByte(8'h02);
    sendByte(8'h00);
    @(negedge clk);
    hunting = 1'b1;
    @(posedge clk);
    #1;
    chk(!outValid && !msgDone, "R2 abort", {outValid, msgDone}, 0);
    @(negedge clk);
    hunting = 1'b0;
    sendMsg(2'd1, 14'd2, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0);

    // R3: priority among equal start characters
    startMaint = startData;
    sendMsg(2'd1, 14'd2, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0);
    startMaint = startCtrl;
    sendMsg(2'd2, 14'd9, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0);
    startMaint = 8'h90;

    // R10: narrowed mask
    addrMask = 16'h000F;
    sendMsg(2'd1, 14'd2, 8'h32, 1'b0, 1'b0, 1'b1, 1'b0);
    sendMsg(2'd3, 14'd1, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0);

    idleCycle();
    chk(!outValid && !msgDone, "R11 done single", {outValid, msgDone}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule